// File: doc/BRIEF.md
# Serial Register Target with Coherent Time Capture

This block is a two-wire serial (I2C) target that exposes a 32-byte register map through one auto-incrementing byte pointer. A write transaction first loads the pointer with the byte that follows the device address. Any further bytes in that transaction are stored at consecutive locations. A read transaction streams bytes from the pointer onward, one per master acknowledge, until the master refuses a byte or ends the transfer.

The lowest eight locations do not reach the external timekeeping counters directly. They hold shadow copies of those counters. All eight copies are captured in the same clock cycle when a transaction begins on a free bus. A host that reads the time therefore always gets one coherent value, even if the counters roll over during the transfer. Bytes that the host writes into the shadow area are handed back to the counters at STOP, by a one-cycle write strobe with a per-byte mask.

Both bus lines are oversampled by the system clock, which must run at least several times faster than SCL. SDA is driven open-drain through a separate output and enable.

Top module: `i2c_snap_regs`

## Requirements
- R1: The block acknowledges only the 7-bit device address 7'h68 (first byte 8'hD0 for write, 8'hD1 for read). For any other address it leaves SDA released for that acknowledge slot, and for every bit after it, until the next START.
- R2: In a write transaction, the first byte after the device address loads the pointer from its low 5 bits. That byte is acknowledged and does not itself advance the pointer.
- R3: Each further written byte is acknowledged and stored at the pointer. The pointer then advances by one on the acknowledge clock, wrapping from 8'h1F to 8'h00.
- R4: In a read, the byte at the pointer is driven MSB first. SDA changes only while SCL is low. Consecutive bytes follow for as long as the master acknowledges, and the pointer wraps from 8'h1F to 8'h00.
- R5: After a master NACK on a read byte, SDA is released for the rest of the transaction and the pointer does not advance.
- R6: A read that is not preceded by a pointer write begins at the pointer value left by the previous transaction.
- R7: On a START that arrives while the bus is free, byte i of `cnt_i` (bits 8i+7..8i) is copied into location i, for i = 0 to 7, in a single cycle. A repeated START does not recapture, so a transfer started with a repeated START returns the earlier captured value.
- R8: At STOP, `cnt_we` is high for exactly one cycle, with bit i set for each location i in 0..7 written since the capture. In that cycle, `cnt_o` byte i carries location i. If no such location was written, `cnt_we` stays zero.
- R9: After reset, SDA is released, `cnt_we` is zero, the pointer is 0 and every location holds 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_o | output | 1 | SDA output value (always low, open-drain) |
| sda_oe | output | 1 | SDA output enable; high pulls the line low |
| cnt_i | input | 64 | Live counter bytes, byte i at bits 8i+7..8i |
| cnt_o | output | 64 | Shadow locations 0..7 presented for write-back |
| cnt_we | output | 8 | One-cycle per-byte write-back strobe at STOP |

## Verification
The bench builds the block with its default parameters: device address 7'h68, a 32-byte map and eight shadow bytes. This small map brings the pointer wrap from 8'h1F to 8'h00 within a few bytes, and that wrap crosses from plain storage into the shadow area. A single written byte there is enough to show the write-back mask and the single-cycle strobe. Changing `cnt_i` in the middle of a read checks that the captured value stays coherent across repeated STARTs, and that a fresh capture happens only on the next START from a free bus.

// File: rtl/i2c_snap_regs.sv
module i2c_snap_regs #(
  parameter logic [6:0] DEV_ADDR   = 7'h68,
  parameter int         MAP_BYTES  = 32,
  parameter int         SNAP_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_o,
  output logic                    sda_oe,
  input  logic [SNAP_BYTES*8-1:0] cnt_i,
  output logic [SNAP_BYTES*8-1:0] cnt_o,
  output logic [SNAP_BYTES-1:0]   cnt_we
);
  localparam int AW = $clog2(MAP_BYTES);
  localparam int SW = $clog2(SNAP_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_PTR, S_WR, S_RD} st_t;

  st_t                 st;
  logic [1:0]          scl_sy, sda_sy;
  logic                scl_s, sda_s, scl_q, sda_q;
  logic                scl_rise, scl_fall, start_c, stop_c;
  logic [7:0]          regs [MAP_BYTES];
  logic [AW-1:0]       ptr;
  logic [7:0]          shreg, tx;
  logic [3:0]          bitc;
  logic                rw, ack_ok, busy;
  logic [SNAP_BYTES-1:0] dirty;

  assign sda_o    = 1'b0;
  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign scl_rise =  scl_s & ~scl_q;
  assign scl_fall = ~scl_s &  scl_q;
  assign start_c  = scl_s & scl_q &  sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q &  sda_s;

  for (genvar g = 0; g < SNAP_BYTES; g++) begin : g_out
    assign cnt_o[8*g +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      shreg  <= '0;
      tx     <= '0;
      bitc   <= '0;
      rw     <= 1'b0;
      ack_ok <= 1'b0;
      busy   <= 1'b0;
      dirty  <= '0;
      sda_oe <= 1'b0;
      cnt_we <= '0;
      for (int i = 0; i < MAP_BYTES; i++) regs[i] <= '0;
    end else begin
      cnt_we <= '0;
      if (start_c) begin
        st     <= S_DEV;
        bitc   <= '0;
        sda_oe <= 1'b0;
        busy   <= 1'b1;
        if (!busy)
          for (int i = 0; i < SNAP_BYTES; i++) regs[i] <= cnt_i[8*i +: 8];
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        busy   <= 1'b0;
        cnt_we <= dirty;
        dirty  <= '0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (bitc < 4'd8) begin
            if (st != S_RD) shreg <= {shreg[6:0], sda_s};
            bitc <= bitc + 4'd1;
          end else if (bitc == 4'd8) begin
            bitc <= 4'd9;
            if (st == S_WR) ptr <= ptr + 1'b1;
            if (st == S_RD) begin
              ack_ok <= ~sda_s;
              if (!sda_s) ptr <= ptr + 1'b1;
            end
          end
        end else if (scl_fall) begin
          if (bitc == 4'd8) begin
            case (st)
              S_DEV: begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                end else begin
                  st <= S_IDLE;
                end
              end
              S_PTR: begin
                ptr    <= shreg[AW-1:0];
                sda_oe <= 1'b1;
              end
              S_WR: begin
                regs[ptr] <= shreg;
                if (ptr < AW'(SNAP_BYTES)) dirty[ptr[SW-1:0]] <= 1'b1;
                sda_oe <= 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bitc == 4'd9) begin
            bitc <= '0;
            case (st)
              S_DEV: begin
                if (rw) begin
                  st     <= S_RD;
                  tx     <= regs[ptr];
                  sda_oe <= ~regs[ptr][7];
                end else begin
                  st     <= S_PTR;
                  sda_oe <= 1'b0;
                end
              end
              S_PTR: begin
                st     <= S_WR;
                sda_oe <= 1'b0;
              end
              S_RD: begin
                if (ack_ok) begin
                  tx     <= regs[ptr];
                  sda_oe <= ~regs[ptr][7];
                end else begin
                  st     <= S_IDLE;
                  sda_oe <= 1'b0;
                end
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (st == S_RD && bitc != 4'd0) begin
            sda_oe <= ~tx[6];
            tx     <= {tx[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_snap_regs_chk.sv
module i2c_snap_regs_chk #(
  parameter int SNAP_BYTES = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sda_oe,
  input logic                    scl_s,
  input logic                    start_c,
  input logic                    stop_c,
  input logic                    busy,
  input logic                    st_idle,
  input logic [SNAP_BYTES*8-1:0] cnt_i,
  input logic [SNAP_BYTES*8-1:0] cnt_o,
  input logic [SNAP_BYTES-1:0]   cnt_we
);
  assert_oe_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !sda_oe);

  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we != '0) |=> (cnt_we == '0));

  assert_strobe_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we != '0) |-> $past(stop_c));

  assert_snapshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c && !busy) |=> (cnt_o == $past(cnt_i)));
endmodule

bind i2c_snap_regs i2c_snap_regs_chk #(.SNAP_BYTES(SNAP_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_c(start_c), .stop_c(stop_c), .busy(busy), .st_idle(st == S_IDLE),
  .cnt_i(cnt_i), .cnt_o(cnt_o), .cnt_we(cnt_we)
);

// File: tb/i2c_snap_regs_tb.sv
`timescale 1ns/1ps
module i2c_snap_regs_tb;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [63:0] cnt_i = '0;
  logic sda_o, sda_oe, sda_line;
  logic [63:0] cnt_o;
  logic [7:0] cnt_we;

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~(sda_oe & ~sda_o);

  i2c_snap_regs u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .cnt_i(cnt_i), .cnt_o(cnt_o), .cnt_we(cnt_we));

  int nchk = 0, nfail = 0, strobes = 0;
  bit done = 0;
  logic [7:0]  mem [32];
  int          mptr = 0;
  bit          mbusy = 0;
  logic [7:0]  mdirty = '0;
  logic [7:0]  last_we = '0;
  logic [63:0] last_o = '0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && cnt_we != '0) begin
    strobes++;
    last_we = cnt_we;
    last_o  = cnt_o;
  end

  task automatic q_wait(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; q_wait(); m_scl = 1'b1; q_wait();
    m_sda = 1'b0; q_wait(); m_scl = 1'b0; q_wait();
    if (!mbusy) for (int i = 0; i < 8; i++) mem[i] = cnt_i[8*i +: 8];
    mbusy = 1;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q_wait(); m_scl = 1'b1; q_wait();
    m_sda = 1'b1; q_wait(); q_wait();
    mbusy = 0;
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; q_wait(); m_scl = 1'b1; q_wait();
    s = sda_line; q_wait(); m_scl = 1'b0; q_wait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
    clk_bit(~ack, s);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    send_byte(8'hD0, a); check("R1 write address ack", a, 1'b1);
    send_byte(p, a);     check("R2 pointer byte ack", a, 1'b1);
    mptr = p[4:0];
  endtask

  task automatic write_data(input logic [7:0] d);
    logic a;
    send_byte(d, a); check("R3 data byte ack", a, 1'b1);
    mem[mptr] = d;
    if (mptr < 8) mdirty[mptr] = 1'b1;
    mptr = (mptr + 1) % 32;
  endtask

  task automatic read_data(input bit ack, input string req);
    logic [7:0] b;
    recv_byte(ack, b);
    check(req, b, mem[mptr]);
    if (ack) mptr = (mptr + 1) % 32;
  endtask

  task automatic finish_stop(input string req);
    int s0;
    s0 = strobes;
    bus_stop();
    check(req, strobes - s0, (mdirty != 0) ? 1 : 0);
    if (mdirty != 0) begin
      check("R8 strobe mask", last_we, mdirty);
      for (int i = 0; i < 8; i++)
        if (mdirty[i]) check("R8 write-back byte", last_o[8*i +: 8], mem[i]);
    end
    mdirty = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog R1..: run hung, actual=hang expected=finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    for (int i = 0; i < 32; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    check("R9 sda released in reset", sda_oe, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 sda released", sda_oe, 1'b0);
    check("R9 strobe low", cnt_we, 8'h0);
    check("R9 buffers zero", cnt_o, 64'h0);
    cnt_i = 64'h0807_0605_0403_0201;

    // R9 R6: current read right after reset starts at 0
    bus_start();
    send_byte(8'hD1, a); check("R1 read address ack", a, 1'b1);
    read_data(1, "R9 R7 first byte at pointer 0");
    read_data(0, "R4 second byte");
    finish_stop("R8 no strobe on read");

    // R1: foreign address ignored
    bus_start();
    send_byte(8'hD2, a); check("R1 foreign address nack", a, 1'b0);
    send_byte(8'h00, a); check("R1 silent until START", a, 1'b0);
    bus_stop();

    // R2 R3: store in plain area
    bus_start(); set_ptr(8'h10);
    write_data(8'h11); write_data(8'h22); write_data(8'h33);
    finish_stop("R8 no strobe for plain area");

    // R2 R4: random read with repeated start
    bus_start(); set_ptr(8'h10); bus_start();
    send_byte(8'hD1, a); check("R1 read ack after repeated start", a, 1'b1);
    read_data(1, "R4 byte 0x10"); read_data(1, "R4 byte 0x11"); read_data(0, "R4 byte 0x12");
    bus_stop();

    // R6 R5: current read, NACK keeps pointer, then line released
    bus_start(); send_byte(8'hD1, a);
    read_data(0, "R6 current read resumes at last pointer");
    bus_stop();
    bus_start(); send_byte(8'hD1, a);
    read_data(0, "R5 pointer held after NACK");
    recv_byte(0, b); check("R5 sda released after NACK", b, 8'hFF);
    bus_stop();

    // R3: wrap into shadow area, write-back strobe
    bus_start(); set_ptr(8'h1E);
    write_data(8'hA1); write_data(8'hB2); write_data(8'hC3);
    finish_stop("R3 R8 single strobe after wrap write");

    // R4: read wrap
    bus_start(); set_ptr(8'h1E); bus_start(); send_byte(8'hD1, a);
    read_data(1, "R4 byte 0x1E"); read_data(1, "R4 byte 0x1F"); read_data(0, "R4 wrap to 0x00");
    bus_stop();

    // R7: coherent capture while counters move
    bus_start(); set_ptr(8'h00); bus_start(); send_byte(8'hD1, a);
    cnt_i = 64'hF8F7_F6F5_F4F3_F2F1;
    for (int i = 0; i < 8; i++) read_data(i != 7, "R7 captured byte stays coherent");
    bus_stop();
    bus_start(); set_ptr(8'h00); bus_start(); send_byte(8'hD1, a);
    read_data(1, "R7 fresh capture byte 0"); read_data(0, "R7 fresh capture byte 1");
    bus_stop();

    // R8: two shadow bytes written back
    bus_start(); set_ptr(8'h03);
    write_data(8'h5A); write_data(8'hA5);
    finish_stop("R8 one strobe for bytes 3 and 4");

    // R2 R8: pointer-only write, then current read
    bus_start(); set_ptr(8'h11);
    finish_stop("R8 no strobe for pointer-only write");
    bus_start(); send_byte(8'hD1, a);
    read_data(0, "R2 R6 read at loaded pointer");
    bus_stop();

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule